// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a supervisory down-counter that asks for a system reset when software stops refreshing it in time. The counter advances on a slow tick, given as a one-cycle enable `tick_en` in the main clock domain, after that tick passes through a programmable power-of-two divider. When the counter has no more room to count down, the block raises `rst_req` for exactly one clock and reloads itself.

Software reaches the block through a small register write/read port. The divider code and the reload value are protected. A write to either one is only accepted after a special unlock value has been written to the key register. Two other key values refresh the counter and start the watchdog. A stray store therefore cannot reconfigure the watchdog, refresh it or stop it. Once started, the watchdog keeps running until the next system reset.

The key handling is a four-state machine. The states are:
- `ST_IDLE_LOCKED`: stopped, write-protected.
- `ST_IDLE_OPEN`: stopped, writable.
- `ST_RUN_LOCKED`: running, write-protected.
- `ST_RUN_OPEN`: running, writable.

The transitions are:
- The unlock key moves either locked state to its open twin.
- Any other key moves an open state back to its locked twin.
- The start key moves either stopped state to `ST_RUN_LOCKED`.
- No key leaves the two running states for a stopped one.

Top module: `kwd_watchdog`

## Requirements
- R1: After reset the block is stopped and locked. The divider code reads 0, the reload value reads 0xFFF, the counter reads 0xFFF and `rst_req` is low.
- R2: A key write of 0x5555 to address 0 unlocks the registers. Afterwards, writes to address 1 (divider code, bits [2:0]) and address 2 (reload, bits [11:0]) are stored and read back.
- R3: Writes to address 1 or 2 while locked are discarded, and the readback is unchanged.
- R4: Any key write other than 0x5555 re-locks the registers. This includes the refresh and start keys.
- R5: A key write of 0xAAAA loads the counter from the reload register and restarts the divider phase. Refreshing more often than the timeout prevents any `rst_req`.
- R6: A key write of 0xCCCC starts the watchdog and loads the counter from the reload register. Before the start, ticks leave the counter unchanged.
- R7: The divider ratio is 4 × 2^code, so code 3 gives /32 and code 4 gives /64. Codes 6 and 7 both give /256.
- R8: After the edge that accepts a refresh or start key, `rst_req` is high in the cycle following the ((reload+1) × ratio)-th tick-qualified edge. It stays high for one cycle, and the counter reloads at that same edge.
- R9: Once running, no key value stops the watchdog.
- R10: Rewriting the reload value while running does not alter the count in progress. The new value is used at the next refresh or expiry.
- R11: While `tick_en` is low, the counter and the divider phase do not move.
- R12: Reads are combinational. Address 0 returns {running, unlocked} in bits [1:0]. Address 1 returns the divider code, address 2 the reload value and address 3 the live counter. All unused bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 key, 1 divider, 2 reload) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data |
| tick_en | input | 1 | Slow tick, one-cycle enable |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The hardest situation to reach is a change of configuration in the middle of a count. For example, a new reload value is written while the counter is partway down, or the divider phase is caught between ticks when a refresh arrives. The stimulus unlocks, writes and re-locks while the counter runs at /32. It then checks that the live count is untouched and that the new value appears only after a refresh.

A behavioural model tracks every edge, so a misplaced cycle anywhere in those sequences shows up as a mismatch. Timeouts are measured in tick-qualified edges for several codes, including a saturated one. Separate runs cover gated ticks and a refresh cadence faster than the timeout.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int DATA_W = 16;

    localparam logic [DATA_W-1:0] KEY_OPEN    = 16'h5555;
    localparam logic [DATA_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [DATA_W-1:0] KEY_START   = 16'hCCCC;

    localparam logic [1:0] ADDR_KEY = 2'd0;
    localparam logic [1:0] ADDR_DIV = 2'd1;
    localparam logic [1:0] ADDR_RLD = 2'd2;
    localparam logic [1:0] ADDR_CNT = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE_LOCKED = 2'd0,
        ST_IDLE_OPEN   = 2'd1,
        ST_RUN_LOCKED  = 2'd2,
        ST_RUN_OPEN    = 2'd3
    } kwd_state_e;

endpackage

// File: rtl/kwd_keyctl.sv
module kwd_keyctl
    import kwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_val,
    output logic              unlocked,
    output logic              running,
    output logic              load_cmd
);

    kwd_state_e state_q, state_d;
    logic is_open, is_start, is_refresh;

    assign is_open    = (key_val == KEY_OPEN);
    assign is_start   = (key_val == KEY_START);
    assign is_refresh = (key_val == KEY_REFRESH);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (key_wr) begin
            unique case (state_q)
                ST_IDLE_LOCKED: begin
                    if (is_open)       state_d = ST_IDLE_OPEN;
                    else if (is_start) state_d = ST_RUN_LOCKED;
                end
                ST_IDLE_OPEN: begin
                    if (is_open)       state_d = ST_IDLE_OPEN;
                    else if (is_start) state_d = ST_RUN_LOCKED;
                    else               state_d = ST_IDLE_LOCKED;
                end
                ST_RUN_LOCKED: begin
                    if (is_open)       state_d = ST_RUN_OPEN;
                end
                ST_RUN_OPEN: begin
                    if (!is_open)      state_d = ST_RUN_LOCKED;
                end
                default:               state_d = ST_IDLE_LOCKED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE_LOCKED;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unlocked = 1'b0;
        running  = 1'b0;
        unique case (state_q)
            ST_IDLE_LOCKED: begin unlocked = 1'b0; running = 1'b0; end
            ST_IDLE_OPEN:   begin unlocked = 1'b1; running = 1'b0; end
            ST_RUN_LOCKED:  begin unlocked = 1'b0; running = 1'b1; end
            ST_RUN_OPEN:    begin unlocked = 1'b1; running = 1'b1; end
            default:        begin unlocked = 1'b0; running = 1'b0; end
        endcase
    end

    assign load_cmd = key_wr && (is_refresh || is_start);

    // R9
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    // R4
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && !is_open) |=> !unlocked);

    // R2
    unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && is_open) |=> unlocked);

    // R6
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && is_start) |=> running);

endmodule

// File: rtl/kwd_prescaler.sv
module kwd_prescaler #(
    parameter int DIV_W      = 3,
    parameter int BASE_SHIFT = 2,
    parameter int MAX_SHIFT  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick_en,
    input  logic             clear,
    input  logic [DIV_W-1:0] div_code,
    output logic             step
);

    localparam int ACC_W = BASE_SHIFT + MAX_SHIFT;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] limit;
    logic [DIV_W-1:0] eff_code;

    // saturate the code, then form ratio-1
    always_comb begin
        if (div_code > DIV_W'(MAX_SHIFT)) eff_code = DIV_W'(MAX_SHIFT);
        else                              eff_code = div_code;
        limit = ACC_W'((32'd1 << (BASE_SHIFT + int'(eff_code))) - 32'd1);
    end

    assign step = run && tick_en && !clear && (acc_q >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n)                acc_q <= '0;
        else if (clear)            acc_q <= '0;
        else if (run && tick_en) begin
            if (step) acc_q <= '0;
            else      acc_q <= acc_q + 1'b1;
        end
    end

    // R7
    phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (acc_q == '0));

    // R11
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !clear) |=> $stable(acc_q));

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
    parameter int              RLD_W   = 12,
    parameter logic [RLD_W-1:0] RLD_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic             load,
    input  logic [RLD_W-1:0] reload_val,
    output logic [RLD_W-1:0] count,
    output logic             expire
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= RLD_RST;
            expire <= 1'b0;
        end else if (load) begin
            count  <= reload_val;
            expire <= 1'b0;
        end else if (step) begin
            if (count == '0) begin
                count  <= reload_val;
                expire <= 1'b1;
            end else begin
                count  <= count - 1'b1;
                expire <= 1'b0;
            end
        end else begin
            expire <= 1'b0;
        end
    end

    // R8
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

    // R8
    expiry_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (count == $past(reload_val)));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> $past(run));

    // R11
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(count));

endmodule

// File: rtl/kwd_watchdog.sv
module kwd_watchdog
    import kwd_pkg::*;
#(
    parameter int               DIV_W      = 3,
    parameter int               BASE_SHIFT = 2,
    parameter int               MAX_SHIFT  = 6,
    parameter int               RLD_W      = 12,
    parameter logic [RLD_W-1:0] RLD_RST    = 12'hFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tick_en,
    output logic              rst_req
);

    logic             unlocked, running, load_cmd, step;
    logic             key_wr, div_wr, rld_wr;
    logic [DIV_W-1:0] div_q;
    logic [RLD_W-1:0] rld_q;
    logic [RLD_W-1:0] count;

    assign key_wr = wr_en && (wr_addr == ADDR_KEY);
    assign div_wr = wr_en && (wr_addr == ADDR_DIV) && unlocked;
    assign rld_wr = wr_en && (wr_addr == ADDR_RLD) && unlocked;

    kwd_keyctl u_keyctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_val  (wr_data),
        .unlocked (unlocked),
        .running  (running),
        .load_cmd (load_cmd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            rld_q <= RLD_RST;
        end else begin
            if (div_wr) div_q <= wr_data[DIV_W-1:0];
            if (rld_wr) rld_q <= wr_data[RLD_W-1:0];
        end
    end

    kwd_prescaler #(
        .DIV_W      (DIV_W),
        .BASE_SHIFT (BASE_SHIFT),
        .MAX_SHIFT  (MAX_SHIFT)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .tick_en  (tick_en),
        .clear    (load_cmd),
        .div_code (div_q),
        .step     (step)
    );

    kwd_counter #(
        .RLD_W   (RLD_W),
        .RLD_RST (RLD_RST)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (running),
        .step       (step),
        .load       (load_cmd),
        .reload_val (rld_q),
        .count      (count),
        .expire     (rst_req)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_KEY: rd_data[1:0]       = {running, unlocked};
            ADDR_DIV: rd_data[DIV_W-1:0] = div_q;
            ADDR_RLD: rd_data[RLD_W-1:0] = rld_q;
            ADDR_CNT: rd_data[RLD_W-1:0] = count;
            default:  rd_data            = '0;
        endcase
    end

    // R3
    div_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_DIV && !unlocked) |=> $stable(div_q));

    // R3
    rld_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_RLD && !unlocked) |=> $stable(rld_q));

    // R10
    rld_no_disturb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_wr && !step) |=> $stable(count));

endmodule

// File: tb/tb_kwd_watchdog.sv
module tb_kwd_watchdog;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;
    logic        tick_en = 1'b1;
    logic        rst_req;

    int errs = 0;
    int checks = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    kwd_watchdog dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick_en(tick_en), .rst_req(rst_req)
    );

    // behavioural reference model
    int m_run, m_unl, m_div, m_rld, m_cnt, m_acc, m_req;

    function automatic int m_read(input int a);
        case (a)
            0: return m_run * 2 + m_unl;
            1: return m_div;
            2: return m_rld;
            default: return m_cnt;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_unl = 0; m_div = 0; m_rld = 4095;
            m_cnt = 4095; m_acc = 0; m_req = 0;
        end else begin
            int ratio, old_rld, old_unl, n_unl, n_run;
            bit do_load;
            ratio   = 4 << ((m_div > 6) ? 6 : m_div);
            old_rld = m_rld;
            old_unl = m_unl;
            n_unl   = m_unl;
            n_run   = m_run;
            do_load = 1'b0;
            if (wr_en && wr_addr == 2'd0) begin
                n_unl = (wr_data == 16'h5555) ? 1 : 0;
                if (wr_data == 16'hCCCC) n_run = 1;
                if (wr_data == 16'hAAAA || wr_data == 16'hCCCC) do_load = 1'b1;
            end
            if (wr_en && wr_addr == 2'd1 && old_unl == 1) m_div = wr_data & 7;
            if (wr_en && wr_addr == 2'd2 && old_unl == 1) m_rld = wr_data & 12'hFFF;
            m_req = 0;
            if (do_load) begin
                m_cnt = old_rld; m_acc = 0;
            end else if (m_run == 1 && tick_en) begin
                if (m_acc + 1 >= ratio) begin
                    m_acc = 0;
                    if (m_cnt == 0) begin m_req = 1; m_cnt = old_rld; end
                    else m_cnt = m_cnt - 1;
                end else m_acc = m_acc + 1;
            end
            m_unl = n_unl;
            m_run = n_run;
        end
        #2;
        if (rst_n && !done) begin
            checks++;
            if (int'(rst_req) != m_req) begin
                errs++;
                $display("FAIL R8 rst_req got %0d exp %0d at %0t", rst_req, m_req, $time);
            end
            checks++;
            if (int'(rd_data) != m_read(int'(rd_addr))) begin
                errs++;
                $display("FAIL R12 rd_data[a=%0d] got %0h exp %0h at %0t",
                         rd_addr, rd_data, m_read(int'(rd_addr)), $time);
            end
            if (rst_req) pulses++;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errs++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic measure(output int n);
        n = 0;
        while (n < 5000) begin
            @(negedge clk);
            n++;
            if (rst_req) break;
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int v, v2, n, p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        rd(2'd0, v); chk("R1 status", v, 0);
        rd(2'd1, v); chk("R1 div", v, 0);
        rd(2'd2, v); chk("R1 reload", v, 12'hFFF);
        rd(2'd3, v); chk("R1 count", v, 12'hFFF);
        chk("R1 rst_req", int'(rst_req), 0);

        // R3 locked writes dropped
        wr(2'd1, 16'd5);   rd(2'd1, v); chk("R3 div locked", v, 0);
        wr(2'd2, 16'h010); rd(2'd2, v); chk("R3 reload locked", v, 12'hFFF);

        // R2 unlock then write
        wr(2'd0, 16'h5555); rd(2'd0, v); chk("R2 unlocked", v, 1);
        wr(2'd2, 16'h00A);  rd(2'd2, v); chk("R2 reload write", v, 12'h00A);

        // R4 relock with foreign key
        wr(2'd0, 16'h1234); rd(2'd0, v); chk("R4 relocked", v, 0);
        wr(2'd2, 16'h005);  rd(2'd2, v); chk("R4 write after relock", v, 12'h00A);

        // R6 counter frozen before start
        repeat (20) @(negedge clk);
        rd(2'd3, v); chk("R6 idle count", v, 12'hFFF);
        chk("R6 no pulse idle", pulses, 0);

        // R6 start; R8 timeout (10+1)*4
        wr(2'd0, 16'hCCCC);
        rd(2'd0, v); chk("R6 running", v, 2);
        rd(2'd3, v); chk("R6 start loads", v, 12'h00A);
        measure(n); chk("R8 timeout /4", n, 44);
        rd(2'd3, v); chk("R8 reload on expiry", v, 12'h00A);
        @(negedge clk); chk("R8 single pulse", int'(rst_req), 0);

        // R7 code 3 -> /32, reload 1; refresh key relocks (R4)
        wr(2'd0, 16'h5555); wr(2'd1, 16'd3); wr(2'd2, 16'd1);
        wr(2'd0, 16'hAAAA);
        rd(2'd0, v); chk("R4 refresh relocks", v, 2);
        measure(n); chk("R7 timeout /32", n, 64);

        // R10 reload rewrite mid-count
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'h0FF);
        rd(2'd3, v); chk("R10 count untouched", (v <= 1) ? 1 : 0, 1);
        wr(2'd0, 16'hAAAA);
        rd(2'd3, v); chk("R10 new reload on refresh", v, 12'h0FF);

        // R7 code 4 -> /64 and saturation at code 7 -> /256
        wr(2'd0, 16'h5555); wr(2'd1, 16'd4); wr(2'd2, 16'd0);
        wr(2'd0, 16'hAAAA);
        measure(n); chk("R7 timeout /64", n, 64);
        wr(2'd0, 16'h5555); wr(2'd1, 16'd7);
        wr(2'd0, 16'hAAAA);
        measure(n); chk("R7 timeout code7 /256", n, 256);
        wr(2'd0, 16'h5555); wr(2'd1, 16'd6);
        wr(2'd0, 16'hAAAA);
        measure(n); chk("R7 timeout code6 /256", n, 256);

        // R5 frequent refresh blocks expiry (timeout 8 ticks)
        wr(2'd0, 16'h5555); wr(2'd1, 16'd0); wr(2'd2, 16'd1);
        wr(2'd0, 16'hAAAA);
        p0 = pulses;
        for (int i = 0; i < 20; i++) begin
            repeat (4) @(negedge clk);
            wr(2'd0, 16'hAAAA);
        end
        chk("R5 refresh prevents expiry", pulses - p0, 0);

        // R11 tick gating
        @(negedge clk); tick_en = 1'b0;
        rd(2'd3, v);
        p0 = pulses;
        repeat (50) @(negedge clk);
        rd(2'd3, v2); chk("R11 count frozen", v2, v);
        chk("R11 no pulse", pulses - p0, 0);
        tick_en = 1'b1;
        measure(n); chk("R11 resumes", (n <= 8) ? 1 : 0, 1);

        // R9 no key stops it
        wr(2'd0, 16'h0000); wr(2'd0, 16'hFFFF); wr(2'd0, 16'h5555);
        wr(2'd0, 16'h1234);
        rd(2'd0, v); chk("R9 still running", v, 2);
        wr(2'd0, 16'hAAAA);
        measure(n); chk("R9 keeps expiring", n, 8);

        repeat (3) @(negedge clk);
        summary();
    end

endmodule